// File: doc/BRIEF.md
# Byte-wide GPIO port with pin-change and mapped-pin interrupts

This block drives and samples a byte-wide group of general-purpose pins through a small register interface. Each pin has its own direction bit and output data bit. The incoming pin levels pass through a two-flop synchroniser, and software reads a merged port value: outputs show what is being driven and inputs show the synchronised pin level.

Two interrupt sources share one status register. A port-wide detector flags any transition seen on any synchronised pin. Four independent channels each watch one pin chosen by a 3-bit index. Each channel fires on a rising edge, a falling edge, a high level or a low level. Status bits are cleared by writing ones. A per-bit enable register gates the status bits onto the single interrupt output.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the direction register is 0 (all pins inputs), pin_oe and pin_out are 0, the status register reads 0 and irq is low.
- R2: A write to address 0 sets the direction register (bit=1 means output) and pin_oe follows it from the next cycle. A write to address 1 sets the output register, which appears on pin_out.
- R3: A read of address 2 returns, per bit, the output register value where the direction bit is 1 and the synchronised pin_in value where it is 0. A pin_in change shows in this readback after exactly two rising clock edges.
- R4: Status bit 4 sets when any synchronised pin differs from its value one cycle earlier. It is visible after the third rising edge following the pin change.
- R5: A channel n configured at address 8+n with bits [4:3]=00 sets status bit n on a rising edge of the pin selected by bits [2:0].
- R6: Condition 01 sets the channel status bit on a falling edge of the selected pin.
- R7: Condition 10 sets the channel status bit while the selected pin is high, and condition 11 while it is low. Such a bit sets again at once after a clear while the level persists.
- R8: Writing address 4 clears each status bit written with 1 and leaves bits written with 0 unchanged. A cleared edge-triggered bit stays clear without a new event.
- R9: irq is the OR of status bits ANDed with the enable register at address 3, which uses the same bit positions as status (bits 3:0 channels, bit 4 change).
- R10: A channel ignores every pin other than the one its index selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | PORT_W | Write data |
| bus_rdata | output | PORT_W | Read data for bus_addr (combinational) |
| pin_in | input | PORT_W | Asynchronous pin levels |
| pin_out | output | PORT_W | Output data to the pins |
| pin_oe | output | PORT_W | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults, eight pins and four channels. With these values a 3-bit index reaches every pin, and the status and enable fields fit in one byte next to the change bit. Four channels let rising, falling and level conditions be set on different pins at once. An unselected pin can then be toggled to show that a channel ignores it, while the port-wide detector still reacts.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    COND_RISE = 2'b00,
    COND_FALL = 2'b01,
    COND_HIGH = 2'b10,
    COND_LOW  = 2'b11
  } cond_e;

  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] A_DIR  = 4'd0;
  localparam logic [REG_AW-1:0] A_OUT  = 4'd1;
  localparam logic [REG_AW-1:0] A_PIN  = 4'd2;
  localparam logic [REG_AW-1:0] A_IEN  = 4'd3;
  localparam logic [REG_AW-1:0] A_STAT = 4'd4;
  localparam logic [REG_AW-1:0] A_CFG0 = 4'd8;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prv_o
);
  logic [WIDTH-1:0] meta_q, lvl_q, prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prv_q  <= '0;
    end else begin
      meta_q <= raw_i;
      lvl_q  <= meta_q;
      prv_q  <= lvl_q;
    end
  end

  assign lvl_o = lvl_q;
  assign prv_o = prv_q;
endmodule

// File: rtl/gpio_w1c_flag.sv
module gpio_w1c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (hit_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/gpio_chan.sv
module gpio_chan
  import gpio_irq_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int SEL_W  = $clog2(PORT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] lvl_i,
  input  logic [PORT_W-1:0] prv_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [1:0]        cond_i,
  input  logic              clr_i,
  output logic              flag_o
);
  logic cur, old, hit;

  always_comb begin
    cur = lvl_i[sel_i];
    old = prv_i[sel_i];
    unique case (cond_e'(cond_i))
      COND_RISE: hit = cur & ~old;
      COND_FALL: hit = ~cur & old;
      COND_HIGH: hit = cur;
      COND_LOW:  hit = ~cur;
      default:   hit = 1'b0;
    endcase
  end

  gpio_w1c_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (hit),
    .clr_i  (clr_i),
    .flag_o (flag_o)
  );
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              bus_we,
  input  logic [3:0]        bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic              irq
);
  localparam int SEL_W = $clog2(PORT_W);
  localparam int CFG_W = SEL_W + 2;
  localparam int ST_W  = NUM_CH + 1;

  logic                  rst_n;
  logic [PORT_W-1:0]     dir_q, dir_d, out_q, out_d;
  logic [ST_W-1:0]       ien_q, ien_d;
  logic [CFG_W-1:0]      cfg_q [NUM_CH];
  logic [CFG_W-1:0]      cfg_d [NUM_CH];
  logic [PORT_W-1:0]     lvl, prv, pin_read;
  logic [ST_W-1:0]       stat, clr;

  gpio_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  gpio_in_sync #(.WIDTH(PORT_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i (pin_in),
    .lvl_o (lvl),
    .prv_o (prv)
  );

  // next-state for the configuration registers
  always_comb begin
    dir_d = dir_q;
    out_d = out_q;
    ien_d = ien_q;
    clr   = '0;
    if (bus_we && bus_addr == A_DIR)  dir_d = bus_wdata;
    if (bus_we && bus_addr == A_OUT)  out_d = bus_wdata;
    if (bus_we && bus_addr == A_IEN)  ien_d = bus_wdata[ST_W-1:0];
    if (bus_we && bus_addr == A_STAT) clr   = bus_wdata[ST_W-1:0];
    for (int n = 0; n < NUM_CH; n++) begin
      cfg_d[n] = cfg_q[n];
      if (bus_we && bus_addr == A_CFG0 + 4'(n)) cfg_d[n] = bus_wdata[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      ien_q <= '0;
      for (int n = 0; n < NUM_CH; n++) cfg_q[n] <= '0;
    end else begin
      dir_q <= dir_d;
      out_q <= out_d;
      ien_q <= ien_d;
      for (int n = 0; n < NUM_CH; n++) cfg_q[n] <= cfg_d[n];
    end
  end

  // mapped-pin channels
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    gpio_chan #(.PORT_W(PORT_W), .SEL_W(SEL_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lvl),
      .prv_i  (prv),
      .sel_i  (cfg_q[g][SEL_W-1:0]),
      .cond_i (cfg_q[g][CFG_W-1:SEL_W]),
      .clr_i  (clr[g]),
      .flag_o (stat[g])
    );
  end

  // port-wide change detector
  gpio_w1c_flag u_chg (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (|(lvl ^ prv)),
    .clr_i  (clr[NUM_CH]),
    .flag_o (stat[NUM_CH])
  );

  assign pin_read = (dir_q & out_q) | (~dir_q & lvl);
  assign pin_out  = out_q;
  assign pin_oe   = dir_q;
  assign irq      = |(stat & ien_q);

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_DIR:  bus_rdata = dir_q;
      A_OUT:  bus_rdata = out_q;
      A_PIN:  bus_rdata = pin_read;
      A_IEN:  bus_rdata[ST_W-1:0] = ien_q;
      A_STAT: bus_rdata[ST_W-1:0] = stat;
      default: begin
        for (int n = 0; n < NUM_CH; n++)
          if (bus_addr == A_CFG0 + 4'(n)) bus_rdata[CFG_W-1:0] = cfg_q[n];
      end
    endcase
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [3:0]        bus_addr,
  input logic [PORT_W-1:0] bus_wdata,
  input logic [PORT_W-1:0] pin_oe,
  input logic [PORT_W-1:0] dir_q,
  input logic [PORT_W-1:0] pin_read,
  input logic [PORT_W-1:0] lvl,
  input logic [PORT_W-1:0] prv,
  input logic [NUM_CH:0]   stat,
  input logic [NUM_CH:0]   ien_q,
  input logic              irq
);
  assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DIR) |=> pin_oe == $past(bus_wdata));

  assert_readback_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OUT && (&dir_q)) |=> pin_read == $past(bus_wdata));

  assert_chg_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[NUM_CH]) |-> $past(lvl != prv));

  assert_clear_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_STAT && bus_wdata[NUM_CH] && lvl == prv) |=> !stat[NUM_CH]);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.PORT_W(PORT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_oe    (pin_oe),
  .dir_q     (dir_q),
  .pin_read  (pin_read),
  .lvl       (lvl),
  .prv       (prv),
  .stat      (stat),
  .ien_q     (ien_q),
  .irq       (irq)
);

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
  logic       clk = 1'b0;
  logic       arst_n;
  logic       bus_we;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
  logic       irq;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_port u_gpio_irq_port (
    .clk(clk), .arst_n(arst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {dir, out, pin, expected readback}
  localparam logic [31:0] VEC [6] = '{
    32'h00_FF_A5_A5, 32'hFF_3C_00_3C, 32'hF0_5A_0F_5F,
    32'h0F_81_C3_C1, 32'hAA_00_FF_55, 32'h00_00_00_00
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    logic [7:0] v;
    arst_n = 1'b0; bus_we = 1'b0; bus_addr = 4'd0; bus_wdata = 8'h00; pin_in = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) arst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(4'd0, v); chk("R1 dir", v, 8'h00);
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    rd(4'd4, v); chk("R1 status", v, 8'h00);
    chk("R1 irq", irq, 1'b0);

    // R2/R3 vector walk
    foreach (VEC[i]) begin
      wr(4'd0, VEC[i][31:24]);
      wr(4'd1, VEC[i][23:16]);
      @(negedge clk) pin_in = VEC[i][15:8];
      settle();
      chk("R2 pin_oe", pin_oe, VEC[i][31:24]);
      chk("R2 pin_out", pin_out, VEC[i][23:16]);
      rd(4'd2, v); chk("R3 readback", v, VEC[i][7:0]);
    end
    wr(4'd4, 8'hFF);

    // R3 two-edge latency
    @(negedge clk) bus_addr = 4'd2; pin_in = 8'h01;
    @(posedge clk); #2 chk("R3 one edge", bus_rdata, 8'h00);
    @(posedge clk); #2 chk("R3 two edges", bus_rdata, 8'h01);
    settle();
    wr(4'd4, 8'hFF);
    rd(4'd4, v); chk("R8 cleared all", v, 8'h00);

    // R4 change detector on pin 7
    @(negedge clk) bus_addr = 4'd4; pin_in = 8'h81;
    @(posedge clk); @(posedge clk); #2 chk("R4 not yet", bus_rdata[4], 1'b0);
    @(posedge clk); #2 chk("R4 change flag", bus_rdata[4], 1'b1);
    chk("R4 ch0 untouched", bus_rdata[0], 1'b0);

    // R9 gating
    chk("R9 irq masked", irq, 1'b0);
    wr(4'd3, 8'h10); chk("R9 irq on", irq, 1'b1);
    wr(4'd3, 8'h01); chk("R9 irq other bit", irq, 1'b0);

    // R8 write-one-to-clear
    wr(4'd4, 8'h0F); rd(4'd4, v); chk("R8 zero keeps", v[4], 1'b1);
    wr(4'd4, 8'h10); settle(); rd(4'd4, v); chk("R8 one clears", v[4], 1'b0);

    // R5 rising on pin 5, R10 channel 2 on pin 6
    wr(4'd9, 8'h05);
    wr(4'd10, 8'h06);
    wr(4'd4, 8'hFF);
    @(negedge clk) pin_in = 8'hA1;
    settle();
    rd(4'd4, v);
    chk("R5 rise ch1", v[1], 1'b1);
    chk("R10 ch2 ignores pin5", v[2], 1'b0);

    // R6 falling on pin 7
    wr(4'd11, 8'h0F);
    wr(4'd4, 8'hFF);
    @(negedge clk) pin_in = 8'h21;
    settle();
    rd(4'd4, v);
    chk("R6 fall ch3", v[3], 1'b1);
    chk("R5 no rise ch1", v[1], 1'b0);
    chk("R10 ch2 still clear", v[2], 1'b0);

    // R7 high level on pin 0, re-asserts after clear
    wr(4'd8, 8'h10);
    rd(4'd4, v); chk("R7 high sets", v[0], 1'b1);
    wr(4'd4, 8'h01); rd(4'd4, v); chk("R7 high reasserts", v[0], 1'b1);
    @(negedge clk) pin_in = 8'h20;
    settle();
    wr(4'd4, 8'h01); rd(4'd4, v); chk("R7 high gone", v[0], 1'b0);
    wr(4'd8, 8'h18); rd(4'd4, v); chk("R7 low sets", v[0], 1'b1);
    chk("R9 irq ch0", irq, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule